// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling software. It holds one clock-cycle counter and four 32-bit event counters, all controlled by one control word. Each cycle the core presents one strobe per event counter. An event counter adds one for each strobe while the unit is enabled. The cycle counter advances on every clock, or once every 64 clocks when the slow rate is selected. With the slow rate, the cycle count covers 2^38 clocks before it wraps.

Software reaches the control word, the cycle counter, the overflow flags and the four event counters through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational on the address. A counter that wraps from all-ones to zero sets its own overflow flag. An interrupt is raised while any set flag has its enable input high. A flag is cleared by writing a 1 to its bit.

Address map (3-bit address): 0 = control, 1 = cycle counter, 2 = overflow flags, 4..7 = event counters 0..3. Control bits are: bit 0 enable, bit 1 event-counter clear, bit 2 cycle-counter clear, bit 3 slow rate, bits 31:24 identification.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset, the control word reads 0x14000000, the flag word reads 0 and `irq` is 0.
- R2: Control bits 31:24 always read 0x14 and ignore writes. Bits 23:4, bit 2 and bit 1 always read 0. Bits 3 and 0 read back the value last written to them.
- R3: While control bit 0 is 0, no counter changes on strobes or clocks.
- R4: While control bit 0 is 1, event counter i adds one at each clock edge where `evt_strobe[i]` is 1. It wraps from 0xFFFFFFFF to 0, and that wrap sets flag bit i.
- R5: Writing control with bit 1 set clears all four event counters at that edge, even if a strobe arrives in the same cycle. Writing control with bit 1 clear leaves the event counters unchanged.
- R6: Writing control with bit 2 set clears the cycle counter and the divide-by-64 prescaler at that edge.
- R7: With control bit 3 = 0, the cycle counter adds one on every enabled clock. With bit 3 = 1, it adds one only on the 64th enabled clock after a bit-2 clear, and on every 64th enabled clock after that.
- R8: The cycle counter is 32 bits wide. Its wrap from 0xFFFFFFFF to 0 sets flag bit 4.
- R9: A register write to a counter in the same cycle as an increment of that counter loads the written value and discards the increment.
- R10: Writing 1s to the flag word (address 2) clears those flag bits. `irq` is 1 exactly when some flag bit and the matching `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_strobe | input | 4 | One event pulse per event counter |
| irq_en | input | 5 | Interrupt enable per flag (bit 4 = cycle counter) |
| ovf_flags | output | 5 | Overflow flags (bit 4 = cycle counter) |
| irq | output | 1 | Interrupt request |

## Verification
The bench strobes events with the enable bit low. A design that gates on the wrong signal would count those strobes. It sends a strobe in the same cycle as a counter write, and in the same cycle as an event-counter clear. A design with the wrong priority would leave a value one too high. It counts exactly 63 and then 64 edges at the slow rate, which catches an off-by-one prescaler or a prescaler that a clear does not reset. It also drives the cycle counter across its wrap with the interrupt first masked and then enabled, and then clears the flag. This exposes a flag that never sets, an interrupt that ignores its enable, or a flag that cannot be cleared.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 3;
  localparam int unsigned NEV    = 4;
  localparam int unsigned PSW    = 6;
  localparam logic [7:0]  UNIT_ID = 8'h14;

  localparam int unsigned B_EN  = 0;
  localparam int unsigned B_PCL = 1;
  localparam int unsigned B_CCL = 2;
  localparam int unsigned B_DIV = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CYC  = 3'd1;
  localparam logic [AW-1:0] A_FLAG = 3'd2;
  localparam logic [AW-1:0] A_EV0  = 3'd4;

  // Read image of the control word: identification, reserved zeros, stored bits
  function automatic logic [DW-1:0] ctl_image(input logic en, input logic div);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1:DW-8] = UNIT_ID;
    w[B_DIV] = div;
    w[B_EN]  = en;
    return w;
  endfunction

  // Cycle-counter advance: every enabled clock, or when the prescaler is full
  function automatic logic cyc_advance(input logic run, input logic div,
                                       input logic [PSW-1:0] ps);
    return run && (!div || (ps == {PSW{1'b1}}));
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // Only a surviving increment from all-ones is a wrap
  assign wrap = inc && !clr && !load && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [PW-1:0] ps
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ps <= '0;
    else if (clr)  ps <= '0;
    else if (run)  ps <= ps + 1'b1;
  end
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          en,
  output logic          div,
  output logic          ev_clr,
  output logic          cy_clr
);
  // Clear commands are pulses that act at the writing edge only
  assign ev_clr = wr && wdata[B_PCL];
  assign cy_clr = wr && wdata[B_CCL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      div <= 1'b0;
    end else if (wr) begin
      en  <= wdata[B_EN];
      div <= wdata[B_DIV];
    end
  end
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import pmu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NEV-1:0] evt_strobe,
  input  logic [NEV:0]  irq_en,
  output logic [NEV:0]  ovf_flags,
  output logic          irq
);
  localparam int unsigned NFL = NEV + 1;

  logic ctl_wr, ctl_en, ctl_div, ev_clr, cy_clr;
  logic cyc_wr, flag_wr, cyc_step, cyc_wrap;
  logic [PSW-1:0] ps;
  logic [DW-1:0]  cyc_cnt;
  logic [NEV-1:0][DW-1:0] evt_cnt;
  logic [NEV-1:0] evt_wr, evt_wrap;
  logic [NFL-1:0] flag_set, flag_clr;

  assign ctl_wr  = reg_we && (reg_addr == A_CTRL);
  assign cyc_wr  = reg_we && (reg_addr == A_CYC);
  assign flag_wr = reg_we && (reg_addr == A_FLAG);

  pmu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(reg_wdata),
    .en(ctl_en), .div(ctl_div), .ev_clr(ev_clr), .cy_clr(cy_clr)
  );

  pmu_prescale #(.PW(PSW)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(cy_clr), .run(ctl_en), .ps(ps)
  );

  assign cyc_step = cyc_advance(ctl_en, ctl_div, ps);

  pmu_counter #(.W(DW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cy_clr), .load(cyc_wr),
    .load_val(reg_wdata), .inc(cyc_step), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  for (genvar i = 0; i < NEV; i++) begin : g_evt
    assign evt_wr[i] = reg_we && (reg_addr == A_EV0 + AW'(i));
    pmu_counter #(.W(DW)) u_evt (
      .clk(clk), .rst_n(rst_n), .clr(ev_clr), .load(evt_wr[i]),
      .load_val(reg_wdata), .inc(ctl_en && evt_strobe[i]),
      .cnt(evt_cnt[i]), .wrap(evt_wrap[i])
    );
  end

  // A new wrap wins over a clear in the same cycle
  assign flag_set = {cyc_wrap, evt_wrap};
  assign flag_clr = flag_wr ? reg_wdata[NFL-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flags <= '0;
    else        ovf_flags <= (ovf_flags & ~flag_clr) | flag_set;
  end

  assign irq = |(ovf_flags & irq_en);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)      reg_rdata = ctl_image(ctl_en, ctl_div);
    else if (reg_addr == A_CYC)  reg_rdata = cyc_cnt;
    else if (reg_addr == A_FLAG) reg_rdata[NFL-1:0] = ovf_flags;
    else if (reg_addr >= A_EV0)  reg_rdata = evt_cnt[reg_addr - A_EV0];
  end
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          ctl_en,
  input logic          ctl_div,
  input logic          ev_clr,
  input logic          cy_clr,
  input logic          cyc_wr,
  input logic [NEV-1:0] evt_wr,
  input logic [NEV-1:0] evt_wrap,
  input logic [PSW-1:0] ps,
  input logic [DW-1:0]  cyc_cnt,
  input logic [NEV-1:0][DW-1:0] evt_cnt,
  input logic [NEV:0]   ovf_flags
);
  p_id_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[DW-1:DW-8] == UNIT_ID && reg_rdata[2:1] == 2'b00));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !ev_clr && evt_wr == '0) |=> $stable(evt_cnt));

  p_evt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> (evt_cnt == '0));

  p_cyc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cy_clr |=> (cyc_cnt == '0 && ps == '0));

  p_slow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_div && !cy_clr && !cyc_wr && ps != {PSW{1'b1}}) |=> $stable(cyc_cnt));

  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrap != '0) |=> ((ovf_flags[NEV-1:0] & $past(evt_wrap)) == $past(evt_wrap)));

  p_cyc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_wr && !cy_clr) |=> (cyc_cnt == $past(reg_wdata)));
endmodule

bind perf_ctr_unit pmu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_en(ctl_en),
  .ctl_div(ctl_div), .ev_clr(ev_clr), .cy_clr(cy_clr), .cyc_wr(cyc_wr),
  .evt_wr(evt_wr), .evt_wrap(evt_wrap), .ps(ps), .cyc_cnt(cyc_cnt),
  .evt_cnt(evt_cnt), .ovf_flags(ovf_flags)
);

// File: tb/perf_ctr_unit_tb_top.sv
`timescale 1ns/1ps
module perf_ctr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0] evt_strobe = '0;
  logic [4:0] irq_en = '0;
  logic [4:0] ovf_flags;
  logic irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  perf_ctr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe),
    .irq_en(irq_en), .ovf_flags(ovf_flags), .irq(irq)
  );

  // vector: we | addr | wdata | strobes | check addr | expected
  localparam int NV = 12;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h0,        4'hF, 3'd4, 32'h0},        // R3 disabled
    {1'b1, 3'd0, 32'hFF000001, 4'h0, 3'd0, 32'h14000001}, // R2 id ignores write
    {1'b0, 3'd0, 32'h0,        4'h1, 3'd4, 32'h1},        // R4 count
    {1'b0, 3'd0, 32'h0,        4'h3, 3'd4, 32'h2},        // R4
    {1'b0, 3'd0, 32'h0,        4'h0, 3'd5, 32'h1},        // R4 other counter
    {1'b1, 3'd7, 32'hFFFFFFFF, 4'h8, 3'd7, 32'hFFFFFFFF}, // R9 write wins
    {1'b0, 3'd0, 32'h0,        4'h8, 3'd7, 32'h0},        // R4 wrap
    {1'b0, 3'd0, 32'h0,        4'h0, 3'd2, 32'h8},        // R4 flag 3
    {1'b1, 3'd2, 32'h8,        4'h0, 3'd2, 32'h0},        // R10 w1c
    {1'b1, 3'd0, 32'h3,        4'hF, 3'd4, 32'h0},        // R5 clear beats strobe
    {1'b0, 3'd0, 32'h0,        4'h4, 3'd6, 32'h1},        // R4
    {1'b1, 3'd0, 32'h1,        4'h0, 3'd6, 32'h1}         // R5 bit1=0 no effect
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [3:0] ev);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_strobe = ev;
    @(posedge clk);
    #1;
    reg_we = 1'b0; evt_strobe = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(3'd0, v); check("R1 ctrl", v, 32'h14000000);
    rd(3'd2, v); check("R1 flags", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][74], VEC[k][73:71], VEC[k][70:39], VEC[k][38:35]);
      rd(VEC[k][34:32], v);
      check($sformatf("R2-5,9,10 vector %0d", k), v, VEC[k][31:0]);
    end

    // R6 clear, then normal rate R7
    step(1'b1, 3'd0, 32'h5, 4'h0);
    rd(3'd1, v); check("R6 cycle cleared", v, 32'h0);
    step(1'b0, 3'd0, 32'h0, 4'h0);
    rd(3'd1, v); check("R7 one per clock", v, 32'h1);

    // R7 slow rate, started by a clear so the prescaler is zero (R6)
    step(1'b1, 3'd0, 32'hD, 4'h0);
    rd(3'd0, v); check("R2 div bit readback", v, 32'h14000009);
    repeat (63) step(1'b0, 3'd0, 32'h0, 4'h0);
    rd(3'd1, v); check("R7 63 clocks", v, 32'h0);
    step(1'b0, 3'd0, 32'h0, 4'h0);
    rd(3'd1, v); check("R7 64 clocks", v, 32'h1);

    // R3 cycle counter holds when disabled
    step(1'b1, 3'd0, 32'h0, 4'h0);
    rd(3'd1, v);
    repeat (70) step(1'b0, 3'd0, 32'h0, 4'h0);
    begin
      logic [31:0] v2;
      rd(3'd1, v2); check("R3 cycle hold", v2, v);
    end

    // R8 cycle wrap, R10 masking and clear
    step(1'b1, 3'd0, 32'h1, 4'h0);
    step(1'b1, 3'd1, 32'hFFFFFFFE, 4'h0);
    rd(3'd1, v); check("R9 cycle load", v, 32'hFFFFFFFE);
    step(1'b0, 3'd0, 32'h0, 4'h0);
    step(1'b0, 3'd0, 32'h0, 4'h0);
    rd(3'd1, v); check("R8 cycle wrapped", v, 32'h0);
    rd(3'd2, v); check("R8 flag 4", v, 32'h10);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    irq_en = 5'h10;
    #1 check("R10 irq raised", {31'b0, irq}, 32'h1);
    step(1'b1, 3'd2, 32'h10, 4'h0);
    rd(3'd2, v); check("R10 flag cleared", v, 32'h0);
    check("R10 irq dropped", {31'b0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule